// File: doc/BRIEF.md
# Compare Match Output Pin Logic

This block owns the single-bit compare-output state of one timer output channel and decides what a general-purpose I/O pin shows. When a compare match strobe or a software force strobe arrives, a two-bit output action field tells the block what to do to the state. It can toggle the state, clear it, set it, or leave it alone. The state lives in its own register, separate from the pin. Software can therefore preset it with a force strobe while the pin is still configured as an input. When the pin is later switched to output, it starts at a known level.

The pin value comes from the compare-output state whenever the action field is nonzero, and from the port data bit otherwise. The pin drive enable always follows the data-direction bit. The waveform mode input has no part in the port override. It only decides whether strobes act on the state: in the PWM waveform modes, both strobes are ignored, because the PWM action tables belong to a different block. The action field is read combinationally and is never buffered, so a change to it takes effect in the same cycle.

Top module: `cmo_pin_logic`

## Requirements
- R1: After a synchronous active-low reset, `oc_state_o` is 0, and with `com_i` = 00 the pin value equals `port_data_i`.
- R2: With `com_i` = 01 in a non-PWM waveform mode, an event (match or force) inverts `oc_state_o` at the next rising clock edge.
- R3: With `com_i` = 10 in a non-PWM waveform mode, an event makes `oc_state_o` 0 at the next rising clock edge.
- R4: With `com_i` = 11 in a non-PWM waveform mode, an event makes `oc_state_o` 1 at the next rising clock edge.
- R5: With `com_i` = 00, events leave `oc_state_o` unchanged, and `pin_out_o` equals `port_data_i` in the same cycle.
- R6: With `com_i` nonzero, `pin_out_o` equals `oc_state_o` in every waveform mode.
- R7: `pin_oe_o` equals `ddr_i` at all times. A force event changes `oc_state_o` even while `ddr_i` is 0.
- R8: A change of `com_i` acts in the same cycle, both on the pin source and on the action taken at the next edge.
- R9: Without an event, `oc_state_o` keeps its value, including across changes of `wave_mode_i`.
- R10: For `wave_mode_i` values of 2 or above (the PWM modes), match and force strobes leave `oc_state_o` unchanged.
- R11: A match and a force in the same cycle apply the action once. For example, a toggle inverts the state a single time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| match_i | input | 1 | Compare match strobe |
| force_i | input | 1 | Software force strobe |
| com_i | input | 2 | Output action field: 00 none/port, 01 toggle, 10 clear, 11 set |
| wave_mode_i | input | WAVE_W (2) | Waveform mode; values >= PWM_FIRST are PWM modes |
| port_data_i | input | 1 | General I/O port data bit |
| ddr_i | input | 1 | Data direction bit, 1 = output |
| oc_state_o | output | 1 | Internal compare-output state |
| pin_out_o | output | 1 | Value driven onto the pin |
| pin_oe_o | output | 1 | Pin drive enable |

## Verification
The case hardest to reach from the ports is a strobe landing on the state while a particular action, waveform mode, direction and starting state are all in force. Each update depends on the previous state, so a sweep that only walks the inputs keeps revisiting the same few states. Before every combination, the bench therefore presets the state through a force with set or clear, in a non-PWM mode with the pin direction as input. It then applies the stimulus under test. This covers every action, waveform mode, pair of strobes, port bit and direction from both starting states, and checks the pin in the same cycle and the state after the edge.

// File: rtl/cmo_pkg.sv
// Package: shared types for the compare-match output pin logic.
// Assumes a two-bit output action field in the non-PWM encoding.
package cmo_pkg;
    localparam int COM_W = 2;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } oc_action_t;
endpackage

// File: rtl/cmo_action_decode.sv
// Module: turns strobes, action field and waveform mode into one state action.
// Assumes waveform mode values at or above PWM_FIRST are PWM modes, where
// strobes are ignored. Match and force together still yield a single action.
module cmo_action_decode
    import cmo_pkg::*;
#(
    parameter int WAVE_W    = 2,
    parameter int PWM_FIRST = 2
) (
    input  logic              match_i,
    input  logic              force_i,
    input  logic [COM_W-1:0]  com_i,
    input  logic [WAVE_W-1:0] wave_mode_i,
    output oc_action_t        act_o
);
    localparam logic [WAVE_W-1:0] PWM_LIM = WAVE_W'(PWM_FIRST);

    logic is_pwm;
    logic event_hit;

    // Classify the waveform mode and merge the two strobes.
    always_comb begin
        is_pwm    = (wave_mode_i >= PWM_LIM);
        event_hit = match_i | force_i;
    end

    // Select the action for this cycle; the action field is used unbuffered.
    always_comb begin
        if (event_hit && !is_pwm) begin
            act_o = oc_action_t'(com_i);
        end else begin
            act_o = ACT_NONE;
        end
    end
endmodule

// File: rtl/cmo_state_reg.sv
// Module: holds the compare-output state and applies one action per clock.
// Assumes synchronous active-low reset; the state resets to 0.
module cmo_state_reg
    import cmo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  oc_action_t act_i,
    output logic       state_o
);
    logic state_q;

    // Update the state register according to the decoded action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 1'b0;
        end else begin
            unique case (act_i)
                ACT_TOGGLE: state_q <= ~state_q;
                ACT_CLEAR:  state_q <= 1'b0;
                ACT_SET:    state_q <= 1'b1;
                default:    state_q <= state_q;
            endcase
        end
    end

    assign state_o = state_q;

    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_TOGGLE) |=> (state_q != $past(state_q)));
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_CLEAR) |=> !state_q);
    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_SET) |=> state_q);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i == ACT_NONE) |=> $stable(state_q));
endmodule

// File: rtl/cmo_pin_mux.sv
// Module: overrides the port data with the compare-output state on the pin.
// Assumes any nonzero action field selects the override, whatever the
// waveform mode; the drive enable stays with the direction bit.
module cmo_pin_mux
    import cmo_pkg::*;
(
    input  logic [COM_W-1:0] com_i,
    input  logic             oc_state_i,
    input  logic             port_data_i,
    input  logic             ddr_i,
    output logic             pin_out_o,
    output logic             pin_oe_o
);
    // Pick the pin source and pass the direction through.
    always_comb begin
        pin_out_o = (|com_i) ? oc_state_i : port_data_i;
        pin_oe_o  = ddr_i;
    end
endmodule

// File: rtl/cmo_pin_logic.sv
// Module: top of the compare-match output pin logic.
// Assumes match and force are single-cycle strobes in the clk domain.
module cmo_pin_logic
    import cmo_pkg::*;
#(
    parameter int WAVE_W    = 2,
    parameter int PWM_FIRST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match_i,
    input  logic              force_i,
    input  logic [1:0]        com_i,
    input  logic [WAVE_W-1:0] wave_mode_i,
    input  logic              port_data_i,
    input  logic              ddr_i,
    output logic              oc_state_o,
    output logic              pin_out_o,
    output logic              pin_oe_o
);
    oc_action_t act;

    cmo_action_decode #(.WAVE_W(WAVE_W), .PWM_FIRST(PWM_FIRST)) u_dec (
        .match_i     (match_i),
        .force_i     (force_i),
        .com_i       (com_i),
        .wave_mode_i (wave_mode_i),
        .act_o       (act)
    );

    cmo_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act),
        .state_o (oc_state_o)
    );

    cmo_pin_mux u_mux (
        .com_i       (com_i),
        .oc_state_i  (oc_state_o),
        .port_data_i (port_data_i),
        .ddr_i       (ddr_i),
        .pin_out_o   (pin_out_o),
        .pin_oe_o    (pin_oe_o)
    );

    assert_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i != 2'b00) |-> (pin_out_o == oc_state_o));
    assert_port_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (com_i == 2'b00) |-> (pin_out_o == port_data_i));
    assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe_o == ddr_i);
    assert_pwm_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode_i >= WAVE_W'(PWM_FIRST)) |=> $stable(oc_state_o));
    assert_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_i && !force_i) |=> $stable(oc_state_o));
endmodule

// File: tb/tb_cmo_pin_logic.sv
module tb_cmo_pin_logic;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       match_i, force_i, port_data_i, ddr_i;
    logic [1:0] com_i, wave_mode_i;
    logic       oc_state_o, pin_out_o, pin_oe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cmo_pin_logic dut (
        .clk(clk), .rst_n(rst_n), .match_i(match_i), .force_i(force_i),
        .com_i(com_i), .wave_mode_i(wave_mode_i), .port_data_i(port_data_i),
        .ddr_i(ddr_i), .oc_state_o(oc_state_o), .pin_out_o(pin_out_o),
        .pin_oe_o(pin_oe_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Preset the state through a force while the pin is an input (R7 path).
    task automatic preset(input logic s);
        @(negedge clk);
        com_i = s ? 2'b11 : 2'b10; wave_mode_i = 2'd0;
        force_i = 1'b1; match_i = 1'b0; ddr_i = 1'b0;
        @(negedge clk);
        force_i = 1'b0;
        chk("R7 preset with direction input", oc_state_o, s);
    endtask

    initial begin
        rst_n = 1'b0; match_i = 0; force_i = 0; com_i = 0;
        wave_mode_i = 0; port_data_i = 1'b1; ddr_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset state", oc_state_o, 1'b0);
        chk("R1 pin follows port", pin_out_o, 1'b1);

        // Near-exhaustive sweep over all inputs from both starting states.
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 4; c++)
                for (int w = 0; w < 4; w++)
                    for (int e = 0; e < 4; e++)
                        for (int pd = 0; pd < 2; pd++)
                            for (int d = 0; d < 2; d++) begin
                                logic exp_s;
                                string tag;
                                preset(s[0]);
                                com_i = c[1:0]; wave_mode_i = w[1:0];
                                match_i = e[0]; force_i = e[1];
                                port_data_i = pd[0]; ddr_i = d[0];
                                #1;
                                chk(c == 0 ? "R5 pin from port" : "R6 pin from state",
                                    pin_out_o, c == 0 ? pd[0] : s[0]);
                                chk("R7 drive enable", pin_oe_o, d[0]);
                                exp_s = s[0];
                                if (e != 0 && w < 2) begin
                                    if (c == 1) exp_s = ~s[0];
                                    else if (c == 2) exp_s = 1'b0;
                                    else if (c == 3) exp_s = 1'b1;
                                end
                                if (e == 0) tag = "R9 hold";
                                else if (w >= 2) tag = "R10 pwm ignore";
                                else if (e == 3 && c != 0) tag = "R11 single action";
                                else if (c == 0) tag = "R5 no action";
                                else if (c == 1) tag = "R2 toggle";
                                else if (c == 2) tag = "R3 clear";
                                else tag = "R4 set";
                                @(negedge clk);
                                match_i = 0; force_i = 0;
                                #1;
                                chk(tag, oc_state_o, exp_s);
                            end

        // R8: change of the action field mid-cycle acts immediately.
        preset(1'b1);
        com_i = 2'b00; port_data_i = 1'b0; #1;
        chk("R8 pin from port", pin_out_o, 1'b0);
        com_i = 2'b01; match_i = 1'b1; #1;
        chk("R8 pin switches at once", pin_out_o, 1'b1);
        @(negedge clk); match_i = 0; #1;
        chk("R8 new action used", oc_state_o, 1'b0);

        // R9: waveform mode changes alone keep the state.
        preset(1'b1);
        for (int w = 0; w < 4; w++) begin
            wave_mode_i = w[1:0];
            @(negedge clk); #1;
            chk("R9 hold across mode change", oc_state_o, 1'b1);
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule